// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block is the per-endpoint response logic of a USB device serial interface engine. Each token that reaches the endpoint produces one response code. The code is chosen from four inputs: a two-bit response mode held in a software-written configuration register, the direction of the endpoint, its transfer type, and whether the bus-side buffer is ready. The block tracks when buffer state causes a NAK, and it stalls the endpoint by itself when an OUT packet is longer than the configured maximum packet size.

The 16-bit configuration register holds the following fields:

- a response mode in bits 15:14;
- a reserved bit 13 that always reads 0;
- an automatic zero-length-packet enable in bit 12;
- an OUT buffer clear mode in bit 11;
- a byte-wide data-register select in bit 10;
- the maximum packet size in bits 9:0.

Packet encoding, CRC and the FIFO data path are outside the block. One copy of the block serves one endpoint.

Top module: `usb_ep_resp_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x0040. Bit 13 always reads 0, even after software writes 1 to it.
- R2: When the mode is 00 on a non-isochronous endpoint, the response is NAK whatever the buffer state.
- R3: When the mode is 10 or 11 on a non-isochronous endpoint, the response is STALL whatever the buffer state.
- R4: When the mode is 01 on a non-isochronous OUT endpoint, the response is ACK if the receive buffer is ready and NAK if it is not.
- R5: When the mode is 01 on a non-isochronous IN endpoint, the response is DATA if the transmit buffer is ready and NAK otherwise, except in the R9 case.
- R6: A not-ready event sets the sticky flag nrdy_o. A not-ready event is a token in mode 01, or any isochronous token, that meets a bus-side buffer that is not ready and does not fall under R7 or R9. A pulse on nrdy_clr_i clears the flag. If a not-ready event comes in the same cycle as the clear, the event wins.
- R7: An OUT token with rx_len_i greater than the maximum packet size writes 10 into bits 15:14, whatever value those bits held before. This write-back overrides a software write to those bits in the same cycle. The oversize token itself gets STALL, or NONE on an isochronous endpoint.
- R8: On an isochronous endpoint (transfer type 11) the mode bits are ignored. An OUT token gets NONE, meaning no handshake. An IN token gets DATA if the transmit buffer is ready, and ZLP otherwise.
- R9: When bit 12 is set, the mode is 01 and the last DATA sent had a tx_len_i equal to the maximum packet size, the next IN token that finds the transmit buffer not ready gets ZLP instead of NAK. That token raises no not-ready event. A ZLP, or a DATA of any other length, disarms this condition.
- R10: resp_valid_o is high for exactly the one cycle after each cycle in which tok_valid_i is high, and at no other time. The response codes on resp_o are: 0 NONE, 1 ACK, 2 NAK, 3 STALL, 4 DATA, 5 ZLP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration register contents |
| xfer_type_i | input | 2 | Transfer type: 00 control, 01 bulk, 10 interrupt, 11 isochronous |
| ep_dir_in_i | input | 1 | Endpoint direction, 1 = IN |
| tok_valid_i | input | 1 | A token for this endpoint is present this cycle |
| rx_ready_i | input | 1 | Bus-side buffer is ready to receive |
| tx_ready_i | input | 1 | Bus-side buffer is ready to transmit |
| rx_len_i | input | 11 | Byte count of the received OUT packet |
| tx_len_i | input | 11 | Byte count of the IN packet being sent |
| nrdy_clr_i | input | 1 | Clears the not-ready flag |
| resp_valid_o | output | 1 | Response present |
| resp_o | output | 3 | Response code |
| nrdy_o | output | 1 | Sticky not-ready flag |
| zlp_auto_o | output | 1 | Automatic zero-length-packet enable (bit 12) |
| buf_clr_o | output | 1 | OUT buffer clear mode (bit 11) |
| byte_mode_o | output | 1 | Byte-wide data register select (bit 10) |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a not-ready event and a software clear of the flag. The bench drives a token at a not-ready buffer in the same cycle as nrdy_clr_i, and expects nrdy_o to read 1 after that edge. The second pair is the oversize write-back and a software write to the mode bits. The bench drives an oversize OUT token together with a configuration write of mode 01, and expects bits 15:14 to read 10.

// File: rtl/ep_resp_pkg.sv
package ep_resp_pkg;
  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_DATA  = 3'd4,
    RSP_ZLP   = 3'd5
  } rsp_e;

  localparam logic [1:0] XT_ISO    = 2'b11;
  localparam logic [1:0] MODE_NAK  = 2'b00;
  localparam logic [1:0] MODE_BUF  = 2'b01;
  localparam logic [1:0] MODE_STWB = 2'b10;
endpackage

// File: rtl/ep_cfg_reg.sv
module ep_cfg_reg #(
  parameter int unsigned CFG_W   = 16,
  parameter int unsigned MPS_W   = 10,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h0040
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             stall_set_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [1:0]       mode_o,
  output logic             zlp_en_o,
  output logic             buf_clr_o,
  output logic             byte_mode_o,
  output logic [MPS_W-1:0] mps_o
);
  import ep_resp_pkg::*;

  localparam int unsigned MODE_LO = CFG_W - 2;
  localparam int unsigned RSV_B   = CFG_W - 3;
  localparam int unsigned ZLP_B   = CFG_W - 4;
  localparam int unsigned CLR_B   = CFG_W - 5;
  localparam int unsigned BYTE_B  = CFG_W - 6;

  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = wdata_i;
    cfg_d[RSV_B] = 1'b0;
    // hardware stall write-back beats a same-cycle software write
    if (stall_set_i) cfg_d[CFG_W-1:MODE_LO] = MODE_STWB;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o       = cfg_q;
  assign mode_o      = cfg_q[CFG_W-1:MODE_LO];
  assign zlp_en_o    = cfg_q[ZLP_B];
  assign buf_clr_o   = cfg_q[CLR_B];
  assign byte_mode_o = cfg_q[BYTE_B];
  assign mps_o       = cfg_q[MPS_W-1:0];

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !cfg_o[RSV_B]); // R1
  AST_STALL_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_set_i |=> (mode_o == MODE_STWB)); // R7
endmodule

// File: rtl/ep_resp_decide.sv
module ep_resp_decide (
  input  logic       tok_i,
  input  logic [1:0] mode_i,
  input  logic       iso_i,
  input  logic       dir_in_i,
  input  logic       rx_ready_i,
  input  logic       tx_ready_i,
  input  logic       oversize_i,
  input  logic       zlp_ok_i,
  output logic [2:0] rsp_o,
  output logic       nrdy_evt_o,
  output logic       stall_set_o
);
  import ep_resp_pkg::*;

  rsp_e rsp;
  logic evt, stset;

  always_comb begin
    rsp   = RSP_NONE;
    evt   = 1'b0;
    stset = 1'b0;
    if (iso_i) begin
      if (dir_in_i) begin
        rsp = tx_ready_i ? RSP_DATA : RSP_ZLP;
        evt = !tx_ready_i;
      end else if (oversize_i) begin
        stset = 1'b1;
      end else begin
        evt = !rx_ready_i;
      end
    end else if (!dir_in_i && oversize_i) begin
      rsp   = RSP_STALL;
      stset = 1'b1;
    end else if (mode_i[1]) begin
      rsp = RSP_STALL;
    end else if (mode_i == MODE_NAK) begin
      rsp = RSP_NAK;
    end else if (dir_in_i) begin
      if (tx_ready_i)    rsp = RSP_DATA;
      else if (zlp_ok_i) rsp = RSP_ZLP;
      else begin
        rsp = RSP_NAK;
        evt = 1'b1;
      end
    end else begin
      rsp = rx_ready_i ? RSP_ACK : RSP_NAK;
      evt = !rx_ready_i;
    end
  end

  assign rsp_o       = rsp;
  assign nrdy_evt_o  = tok_i && evt;
  assign stall_set_o = tok_i && stset;
endmodule

// File: rtl/ep_nrdy_flag.sv
module ep_nrdy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (evt_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_NRDY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o); // R6
  AST_NRDY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !flag_o); // R6
endmodule

// File: rtl/ep_zlp_track.sv
module ep_zlp_track #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned MPS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_i,
  input  logic [2:0]       rsp_i,
  input  logic [LEN_W-1:0] tx_len_i,
  input  logic [MPS_W-1:0] mps_i,
  output logic             armed_o
);
  import ep_resp_pkg::*;

  localparam int unsigned PAD_W = LEN_W - MPS_W;

  logic armed_q;
  logic full_pkt;

  assign full_pkt = (tx_len_i == {{PAD_W{1'b0}}, mps_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (tok_i && rsp_i == RSP_DATA) armed_q <= full_pkt;
    else if (tok_i && rsp_i == RSP_ZLP)  armed_q <= 1'b0;
  end

  assign armed_o = armed_q;

  AST_ZLP_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_i && rsp_i == RSP_ZLP) |=> !armed_o); // R9
endmodule

// File: rtl/usb_ep_resp_ctrl.sv
module usb_ep_resp_ctrl #(
  parameter int unsigned CFG_W   = 16,
  parameter int unsigned MPS_W   = 10,
  parameter int unsigned LEN_W   = 11,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h0040
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic [1:0]       xfer_type_i,
  input  logic             ep_dir_in_i,
  input  logic             tok_valid_i,
  input  logic             rx_ready_i,
  input  logic             tx_ready_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic [LEN_W-1:0] tx_len_i,
  input  logic             nrdy_clr_i,
  output logic             resp_valid_o,
  output logic [2:0]       resp_o,
  output logic             nrdy_o,
  output logic             zlp_auto_o,
  output logic             buf_clr_o,
  output logic             byte_mode_o
);
  import ep_resp_pkg::*;

  localparam int unsigned PAD_W = LEN_W - MPS_W;

  logic [1:0]       mode;
  logic [MPS_W-1:0] mps;
  logic             zlp_en, armed, oversize, iso;
  logic [2:0]       rsp_d;
  logic             nrdy_evt, stall_set;
  logic             rvalid_q;
  logic [2:0]       rsp_q;

  assign iso      = (xfer_type_i == XT_ISO);
  assign oversize = !ep_dir_in_i && (rx_len_i > {{PAD_W{1'b0}}, mps});

  ep_cfg_reg #(.CFG_W(CFG_W), .MPS_W(MPS_W), .CFG_RST(CFG_RST)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .stall_set_i (stall_set),
    .cfg_o       (cfg_rdata_o),
    .mode_o      (mode),
    .zlp_en_o    (zlp_en),
    .buf_clr_o   (buf_clr_o),
    .byte_mode_o (byte_mode_o),
    .mps_o       (mps)
  );

  ep_resp_decide u_dec (
    .tok_i       (tok_valid_i),
    .mode_i      (mode),
    .iso_i       (iso),
    .dir_in_i    (ep_dir_in_i),
    .rx_ready_i  (rx_ready_i),
    .tx_ready_i  (tx_ready_i),
    .oversize_i  (oversize),
    .zlp_ok_i    (zlp_en && armed),
    .rsp_o       (rsp_d),
    .nrdy_evt_o  (nrdy_evt),
    .stall_set_o (stall_set)
  );

  ep_nrdy_flag u_nrdy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (nrdy_evt),
    .clr_i  (nrdy_clr_i),
    .flag_o (nrdy_o)
  );

  ep_zlp_track #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_zlp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tok_i    (tok_valid_i),
    .rsp_i    (rsp_d),
    .tx_len_i (tx_len_i),
    .mps_i    (mps),
    .armed_o  (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rsp_q    <= RSP_NONE;
    end else begin
      rvalid_q <= tok_valid_i;
      if (tok_valid_i) rsp_q <= rsp_d;
    end
  end

  assign resp_valid_o = rvalid_q;
  assign resp_o       = rsp_q;
  assign zlp_auto_o   = zlp_en;

  AST_RESP_AFTER_TOK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i |=> resp_valid_o); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i |=> !resp_valid_o); // R10
  AST_ISO_OUT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && iso && !ep_dir_in_i) |=> (resp_o == RSP_NONE)); // R8
  AST_OVERSIZE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && oversize && !iso) |=> (resp_o == RSP_STALL)); // R7
endmodule

// File: tb/usb_ep_resp_ctrl_tb.sv
`timescale 1ns/1ps
module usb_ep_resp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [1:0]  xt = 2'b01;
  logic        dir_in = 1'b0;
  logic        tok = 1'b0;
  logic        rxr = 1'b0, txr = 1'b0;
  logic [10:0] rx_len = '0, tx_len = '0;
  logic        clr = 1'b0;
  logic        rvalid, nrdy, zlp_auto, bclr, bmode;
  logic [2:0]  resp;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  logic [15:0] m_cfg = 16'h0040;
  logic        m_armed = 1'b0;
  logic        m_nrdy = 1'b0;

  always #4 clk = ~clk;

  usb_ep_resp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .xfer_type_i(xt), .ep_dir_in_i(dir_in),
    .tok_valid_i(tok), .rx_ready_i(rxr), .tx_ready_i(txr), .rx_len_i(rx_len),
    .tx_len_i(tx_len), .nrdy_clr_i(clr), .resp_valid_o(rvalid), .resp_o(resp),
    .nrdy_o(nrdy), .zlp_auto_o(zlp_auto), .buf_clr_o(bclr), .byte_mode_o(bmode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops an expected response for every valid (R10)
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 actual=valid expected=idle");
      end else begin
        automatic logic [2:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (resp != e) begin
          errors++;
          $display("FAIL %s actual=%0d expected=%0d", t, resp, e);
        end
      end
    end
  end

  function automatic logic [2:0] model(input logic [1:0] t, input logic din,
      input logic r, input logic x, input logic [10:0] rl,
      output logic evt, output logic stw);
    logic ovs;
    logic [1:0] md;
    ovs = !din && (rl > {1'b0, m_cfg[9:0]});
    md = m_cfg[15:14];
    evt = 1'b0; stw = 1'b0;
    if (t == 2'b11) begin
      if (din) begin evt = !x; return x ? 3'd4 : 3'd5; end
      if (ovs) begin stw = 1'b1; return 3'd0; end
      evt = !r; return 3'd0;
    end
    if (ovs) begin stw = 1'b1; return 3'd3; end
    if (md[1]) return 3'd3;
    if (md == 2'b00) return 3'd2;
    if (din) begin
      if (x) return 3'd4;
      if (m_cfg[12] && m_armed) return 3'd5;
      evt = 1'b1; return 3'd2;
    end
    evt = !r;
    return r ? 3'd1 : 3'd2;
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    m_cfg = d; m_cfg[13] = 1'b0;
  endtask

  task automatic send(input string req, input logic [1:0] t, input logic din,
      input logic r, input logic x, input logic [10:0] rl, input logic [10:0] tl,
      input logic c, input logic we, input logic [15:0] wd);
    logic evt, stw;
    logic [2:0] e;
    @(negedge clk);
    e = model(t, din, r, x, rl, evt, stw);
    xt = t; dir_in = din; rxr = r; txr = x; rx_len = rl; tx_len = tl;
    clr = c; cfg_we = we; cfg_wdata = wd; tok = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    if (we) begin m_cfg = wd; m_cfg[13] = 1'b0; end
    if (stw) m_cfg[15:14] = 2'b10;
    if (evt) m_nrdy = 1'b1; else if (c) m_nrdy = 1'b0;
    if (e == 3'd4) m_armed = (tl == {1'b0, m_cfg[9:0]});
    else if (e == 3'd5) m_armed = 1'b0;
    @(negedge clk);
    tok = 1'b0; clr = 1'b0; cfg_we = 1'b0;
    #1;
    chk({req, " resp-count"}, exp_q.size(), 0);
    chk({req, " nrdy"}, int'(nrdy), int'(m_nrdy));
    chk({req, " cfg"}, int'(cfg_rdata), int'(m_cfg));
  endtask

  task automatic clear_nrdy();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    m_nrdy = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset cfg", int'(cfg_rdata), 16'h0040);
    chk("R1 reset nrdy", int'(nrdy), 0);
    chk("R10 reset valid", int'(rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reserved bit stays 0
    wr(16'h2040);
    #1 chk("R1 rsv bit", int'(cfg_rdata), 16'h0040);
    wr(16'h1C40);
    #1 chk("R1 field outs", {29'd0, zlp_auto, bclr, bmode}, 3'b111);

    // R2: mode 00
    wr(16'h0040);
    send("R2 out rdy", 2'b01, 1'b0, 1'b1, 1'b1, 11'd8, 11'd0, 1'b0, 1'b0, 16'h0);
    send("R2 in rdy", 2'b10, 1'b1, 1'b1, 1'b1, 11'd0, 11'd4, 1'b0, 1'b0, 16'h0);
    // R3: modes 10/11
    wr(16'hC040);
    send("R3 out", 2'b01, 1'b0, 1'b1, 1'b1, 11'd8, 11'd0, 1'b0, 1'b0, 16'h0);
    wr(16'h8040);
    send("R3 in", 2'b00, 1'b1, 1'b0, 1'b1, 11'd0, 11'd4, 1'b0, 1'b0, 16'h0);
    // R4
    wr(16'h4040);
    send("R4 ack", 2'b01, 1'b0, 1'b1, 1'b0, 11'd64, 11'd0, 1'b0, 1'b0, 16'h0);
    send("R4 nak", 2'b01, 1'b0, 1'b0, 1'b0, 11'd8, 11'd0, 1'b0, 1'b0, 16'h0);
    clear_nrdy();
    #1 chk("R6 clear", int'(nrdy), 0);
    // R6 collision: event beats clear
    send("R6 collide", 2'b10, 1'b0, 1'b0, 1'b1, 11'd8, 11'd0, 1'b1, 1'b0, 16'h0);
    send("R6 clr-ready", 2'b10, 1'b0, 1'b1, 1'b1, 11'd8, 11'd0, 1'b1, 1'b0, 16'h0);
    // R5
    send("R5 data", 2'b01, 1'b1, 1'b0, 1'b1, 11'd0, 11'd10, 1'b0, 1'b0, 16'h0);
    send("R5 nak", 2'b01, 1'b1, 1'b1, 1'b0, 11'd0, 11'd0, 1'b0, 1'b0, 16'h0);
    clear_nrdy();
    // R7
    wr(16'h0040);
    send("R7 oversize", 2'b01, 1'b0, 1'b1, 1'b1, 11'd65, 11'd0, 1'b0, 1'b0, 16'h0);
    wr(16'h4040);
    send("R7 collide wr", 2'b10, 1'b0, 1'b0, 1'b1, 11'd100, 11'd0, 1'b0, 1'b1, 16'h4020);
    chk("R7 mode bits", int'(cfg_rdata[15:14]), 2);
    // R8
    wr(16'h4040);
    send("R8 iso out", 2'b11, 1'b0, 1'b1, 1'b1, 11'd40, 11'd0, 1'b0, 1'b0, 16'h0);
    send("R8 iso in zlp", 2'b11, 1'b1, 1'b1, 1'b0, 11'd0, 11'd0, 1'b0, 1'b0, 16'h0);
    clear_nrdy();
    wr(16'h0040);
    send("R8 iso in data", 2'b11, 1'b1, 1'b1, 1'b1, 11'd0, 11'd30, 1'b0, 1'b0, 16'h0);
    send("R8 iso oversize", 2'b11, 1'b0, 1'b1, 1'b1, 11'd65, 11'd0, 1'b0, 1'b0, 16'h0);
    // R9
    wr(16'h5040);
    send("R9 full data", 2'b01, 1'b1, 1'b0, 1'b1, 11'd0, 11'd64, 1'b0, 1'b0, 16'h0);
    send("R9 zlp", 2'b01, 1'b1, 1'b0, 1'b0, 11'd0, 11'd0, 1'b0, 1'b0, 16'h0);
    send("R9 after zlp", 2'b01, 1'b1, 1'b0, 1'b0, 11'd0, 11'd0, 1'b0, 1'b0, 16'h0);
    clear_nrdy();
    send("R9 short data", 2'b01, 1'b1, 1'b0, 1'b1, 11'd0, 11'd12, 1'b0, 1'b0, 16'h0);
    send("R9 no arm", 2'b01, 1'b1, 1'b0, 1'b0, 11'd0, 11'd0, 1'b0, 1'b0, 16'h0);
    // R10: idle cycles raise no valid
    repeat (4) @(negedge clk);
    #1 chk("R10 idle", int'(rvalid), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule